// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide register front end of one eight-line priority interrupt controller. It sits behind a one-bit address and a pair of single-cycle strobes, one for writes and one for reads. A write to the low address either starts the initialization sequence or carries an operation command. A write to the high address feeds the initialization sequence or, once that sequence has finished, loads the line mask.

The block owns the mask, the vector base, the nesting and automatic end-of-interrupt mode flags, rotate-on-auto-EOI, special mask mode and the rotating priority offset. It does not hold the request or in-service bits. An external latch owns those bits and presents them as inputs. An external resolver presents the winning line for poll reads. This block answers by pulsing one-hot clear strobes back to that latch for end-of-interrupt commands and for acknowledged polls.

Read data is registered. It appears one cycle after the read strobe, with a valid flag.

Top module: `pic_prog_if`

## Requirements
- R1: Out of reset every register output is zero: mask, vector base, mode flags, priority offset, clear strobes, read data and read valid. The block is in normal mode (`init_busy` = 0).
- R2: A write to address 0 with data bit 4 set starts initialization and raises `init_busy`.
  - It zeroes the mask, the priority offset, special mask mode and read-select.
  - Data bit 0 records whether a fourth word follows.
  - Nesting and auto-EOI are cleared only when bit 0 is 0; otherwise they keep their values.
- R3: After an init start, the next address-1 write loads `vec_base` with data bits 7:3 (the byte ANDed with 0xF8). The address-1 write after that returns to normal mode if no fourth word was flagged, and otherwise waits for the fourth word.
- R4: The fourth word sets `fully_nested` from data bit 4 and `auto_eoi` from data bit 1, and returns to normal mode.
- R5: In normal mode, an address-1 write loads `mask_q` with the data byte.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode command.
  - Bit 2 = 1 arms a poll.
  - When bit 1 = 1, bit 0 sets read-select (1 = in-service, 0 = request).
  - When bit 6 = 1, bit 5 sets special mask mode.
  - A field whose enable bit is 0 keeps its value.
- R7: An address-0 write with bits 4 and 3 both 0 is an operation command, selected by data bits 7:5. Command 0 clears `rot_auto_eoi` and command 4 sets it.
- R8: Command 1 pulses `isr_clr` for the highest-priority set in-service line, where line `prio_ofs` ranks highest and the ranking continues upward modulo 8. Nothing is pulsed when no in-service bit is set. Command 5 does the same and also sets `prio_ofs` to that line plus 1 (mod 8), but only if a line was found.
- R9: Commands that name a line use data bits 2:0 as the line L.
  - Command 3 pulses `isr_clr` for L.
  - Command 7 pulses `isr_clr` for L and sets `prio_ofs` to L+1.
  - Command 6 only sets `prio_ofs` to L+1.
  - Command 2 changes nothing.
- R10: A read strobe yields `rd_valid` for exactly the next cycle. The data is the in-service input when reading address 0 with read-select 1, the request input when reading address 0 with read-select 0, and `mask_q` when reading address 1.
- R11: With a poll armed, the next read (either address) returns the resolver's line number and pulses both `irr_clr` and `isr_clr` for that line. If the resolver reports nothing, the read returns 0x07 with no strobes. Either way the poll disarms, so the read after it is an ordinary read.
- R12: Clear strobes are one-hot (or zero), appear in the cycle after the causing strobe, and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data byte |
| req_vec | input | 8 | Request bits from the external latch |
| insvc_vec | input | 8 | In-service bits from the external latch |
| res_valid | input | 1 | Resolver has a line to grant |
| res_line | input | 3 | Line chosen by the resolver |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_stb` |
| mask_q | output | 8 | Line mask |
| vec_base | output | 5 | Vector base, bits 7:3 of the vector |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| prio_ofs | output | 3 | Line holding highest priority |
| init_busy | output | 1 | Initialization sequence in progress |
| isr_clr | output | 8 | One-cycle in-service clear strobe |
| irr_clr | output | 8 | One-cycle request clear strobe (poll acknowledge) |

## Verification
The non-specific end-of-interrupt path is swept over every priority offset and every in-service pattern. A design that scanned from line 0 instead of from the offset, or that moved the offset when no line was in service, would pulse the wrong line or leave a stale offset.

The init sequence is run with and without the fourth word, starting from mode flags that are already set. This catches a design that clears nesting and auto-EOI unconditionally or loses its place in the sequence.

Poll reads cover all eight lines and the empty case. The read after each poll is checked as well, so a poll flag that never disarms returns a line number where the mask should be. Mode commands with their enable bits clear must leave read-select and special mask untouched.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;

  // Sequencer state for the initialization words.
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_BASE   = 2'd1,
    ST_CASC   = 2'd2,
    ST_MODE   = 2'd3
  } init_st_e;

  // Operation command codes carried in the top three data bits.
  typedef enum logic [2:0] {
    OC_ROT_OFF    = 3'd0,
    OC_EOI_NS     = 3'd1,
    OC_NOP        = 3'd2,
    OC_EOI_SP     = 3'd3,
    OC_ROT_ON     = 3'd4,
    OC_EOI_ROT    = 3'd5,
    OC_SET_PRI    = 3'd6,
    OC_EOI_SP_ROT = 3'd7
  } ocw_cmd_e;

  // Bit positions inside a written byte.
  localparam int B_INIT    = 4;  // address 0: start of initialization
  localparam int B_FOURTH  = 0;  // init start: fourth word follows
  localparam int B_MODECMD = 3;  // address 0: mode command
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;
  localparam int B_FNM     = 4;  // fourth word
  localparam int B_AEOI    = 1;  // fourth word

endpackage

// File: rtl/pic_prio_find.sv
// Rotating priority search: the line at ofs ranks highest, then ofs+1, ...
// LINES must be a power of two so that the line index wraps naturally.
module pic_prio_find #(
  parameter int LINES = 8
) (
  input  logic [LINES-1:0]         vec,
  input  logic [$clog2(LINES)-1:0] ofs,
  output logic                     hit,
  output logic [$clog2(LINES)-1:0] line
);
  localparam int LW = $clog2(LINES);

  logic [LINES-1:0] rot;
  logic [LW-1:0]    rank;

  always_comb begin
    for (int p = 0; p < LINES; p++) begin
      logic [LW-1:0] idx;
      idx    = LW'(p) + ofs;
      rot[p] = vec[idx];
    end
  end

  always_comb begin
    rank = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (rot[p]) rank = LW'(p);
    end
  end

  assign hit  = |vec;
  assign line = rank + ofs;

endmodule

// File: rtl/pic_init_seq.sv
// Initialization word sequencer; also owns the mask and mode flags.
module pic_init_seq
  import pic_prog_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_init,
  input  logic                        wr_hi,
  input  logic [DW-1:0]               wdata,
  output init_st_e                    state_q,
  output logic [LINES-1:0]            mask_q,
  output logic [DW-$clog2(LINES)-1:0] base_q,
  output logic                        fnm_q,
  output logic                        aeoi_q
);
  localparam int LW = $clog2(LINES);

  logic four_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NORMAL;
      mask_q  <= '0;
      base_q  <= '0;
      fnm_q   <= 1'b0;
      aeoi_q  <= 1'b0;
      four_q  <= 1'b0;
    end else if (wr_init) begin
      four_q  <= wdata[B_FOURTH];
      mask_q  <= '0;
      state_q <= ST_BASE;
      if (!wdata[B_FOURTH]) begin
        fnm_q  <= 1'b0;
        aeoi_q <= 1'b0;
      end
    end else if (wr_hi) begin
      unique case (state_q)
        ST_NORMAL: mask_q <= wdata[LINES-1:0];
        ST_BASE: begin
          base_q  <= wdata[DW-1:LW];
          state_q <= ST_CASC;
        end
        ST_CASC: state_q <= four_q ? ST_MODE : ST_NORMAL;
        ST_MODE: begin
          fnm_q   <= wdata[B_FNM];
          aeoi_q  <= wdata[B_AEOI];
          state_q <= ST_NORMAL;
        end
        default: state_q <= ST_NORMAL;
      endcase
    end
  end

endmodule

// File: rtl/pic_ocw_dec.sv
// Operation/mode command decoder: offset, modes, poll arm, EOI strobes.
module pic_ocw_dec
  import pic_prog_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_init,
  input  logic                     wr_cmd,
  input  logic [DW-1:0]            wdata,
  input  logic [LINES-1:0]         insvc,
  input  logic                     poll_taken,
  output logic [$clog2(LINES)-1:0] ofs_q,
  output logic                     smm_q,
  output logic                     rsel_q,
  output logic                     poll_q,
  output logic                     rot_q,
  output logic [LINES-1:0]         clr_q
);
  localparam int LW = $clog2(LINES);

  ocw_cmd_e      cmd;
  logic          ns_hit;
  logic [LW-1:0] ns_line;
  logic [LW-1:0] arg_line;
  logic          unused_bits;

  assign cmd         = ocw_cmd_e'(wdata[DW-1 -: 3]);
  assign arg_line    = wdata[LW-1:0];
  assign unused_bits = wdata[B_INIT];

  pic_prio_find #(.LINES(LINES)) u_ns (
    .vec  (insvc),
    .ofs  (ofs_q),
    .hit  (ns_hit),
    .line (ns_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
      rot_q  <= 1'b0;
      clr_q  <= '0;
    end else begin
      clr_q <= '0;
      if (poll_taken) poll_q <= 1'b0;
      if (wr_init) begin
        ofs_q  <= '0;
        smm_q  <= 1'b0;
        rsel_q <= 1'b0;
      end else if (wr_cmd) begin
        if (wdata[B_MODECMD]) begin
          if (wdata[B_POLL])    poll_q <= 1'b1;
          if (wdata[B_RSEL_EN]) rsel_q <= wdata[B_RSEL];
          if (wdata[B_SMM_EN])  smm_q  <= wdata[B_SMM];
        end else begin
          unique case (cmd)
            OC_ROT_OFF: rot_q <= 1'b0;
            OC_ROT_ON:  rot_q <= 1'b1;
            OC_EOI_NS: begin
              if (ns_hit) clr_q <= LINES'(1) << ns_line;
            end
            OC_EOI_ROT: begin
              if (ns_hit) begin
                clr_q <= LINES'(1) << ns_line;
                ofs_q <= ns_line + LW'(1);
              end
            end
            OC_EOI_SP: clr_q <= LINES'(1) << arg_line;
            OC_SET_PRI: ofs_q <= arg_line + LW'(1);
            OC_EOI_SP_ROT: begin
              clr_q <= LINES'(1) << arg_line;
              ofs_q <= arg_line + LW'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pic_read_port.sv
// Registered read path: register reads and poll-acknowledge reads.
module pic_read_port #(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_stb,
  input  logic                     addr,
  input  logic                     poll_q,
  input  logic                     rsel_q,
  input  logic [LINES-1:0]         insvc,
  input  logic [LINES-1:0]         req,
  input  logic [LINES-1:0]         mask_q,
  input  logic                     res_valid,
  input  logic [$clog2(LINES)-1:0] res_line,
  output logic                     poll_taken,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid,
  output logic [LINES-1:0]         irr_clr_q,
  output logic [LINES-1:0]         isr_clr_q
);
  localparam logic [DW-1:0] NONE_CODE = DW'(7);

  assign poll_taken = rd_stb & poll_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      irr_clr_q <= '0;
      isr_clr_q <= '0;
    end else begin
      rd_valid  <= rd_stb;
      irr_clr_q <= '0;
      isr_clr_q <= '0;
      if (rd_stb) begin
        if (poll_q) begin
          if (res_valid) begin
            rd_data   <= DW'(res_line);
            irr_clr_q <= LINES'(1) << res_line;
            isr_clr_q <= LINES'(1) << res_line;
          end else begin
            rd_data <= NONE_CODE;
          end
        end else if (addr) begin
          rd_data <= DW'(mask_q);
        end else begin
          rd_data <= rsel_q ? DW'(insvc) : DW'(req);
        end
      end
    end
  end

endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
  import pic_prog_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic                        rd_stb,
  input  logic                        addr,
  input  logic [DW-1:0]               wdata,
  input  logic [LINES-1:0]            req_vec,
  input  logic [LINES-1:0]            insvc_vec,
  input  logic                        res_valid,
  input  logic [$clog2(LINES)-1:0]    res_line,
  output logic [DW-1:0]               rd_data,
  output logic                        rd_valid,
  output logic [LINES-1:0]            mask_q,
  output logic [DW-$clog2(LINES)-1:0] vec_base,
  output logic                        fully_nested,
  output logic                        auto_eoi,
  output logic                        rot_auto_eoi,
  output logic                        special_mask,
  output logic [$clog2(LINES)-1:0]    prio_ofs,
  output logic                        init_busy,
  output logic [LINES-1:0]            isr_clr,
  output logic [LINES-1:0]            irr_clr
);
  init_st_e         state_q;
  logic             wr_init, wr_cmd, wr_hi;
  logic             rsel_q, poll_q, poll_taken;
  logic [LINES-1:0] cmd_clr, poll_isr_clr;

  assign wr_init = wr_stb & ~addr &  wdata[B_INIT];
  assign wr_cmd  = wr_stb & ~addr & ~wdata[B_INIT];
  assign wr_hi   = wr_stb &  addr;

  pic_init_seq #(.DW(DW), .LINES(LINES)) u_init (
    .clk     (clk),
    .rst     (rst),
    .wr_init (wr_init),
    .wr_hi   (wr_hi),
    .wdata   (wdata),
    .state_q (state_q),
    .mask_q  (mask_q),
    .base_q  (vec_base),
    .fnm_q   (fully_nested),
    .aeoi_q  (auto_eoi)
  );

  pic_ocw_dec #(.DW(DW), .LINES(LINES)) u_ocw (
    .clk        (clk),
    .rst        (rst),
    .wr_init    (wr_init),
    .wr_cmd     (wr_cmd),
    .wdata      (wdata),
    .insvc      (insvc_vec),
    .poll_taken (poll_taken),
    .ofs_q      (prio_ofs),
    .smm_q      (special_mask),
    .rsel_q     (rsel_q),
    .poll_q     (poll_q),
    .rot_q      (rot_auto_eoi),
    .clr_q      (cmd_clr)
  );

  pic_read_port #(.DW(DW), .LINES(LINES)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .addr       (addr),
    .poll_q     (poll_q),
    .rsel_q     (rsel_q),
    .insvc      (insvc_vec),
    .req        (req_vec),
    .mask_q     (mask_q),
    .res_valid  (res_valid),
    .res_line   (res_line),
    .poll_taken (poll_taken),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .irr_clr_q  (irr_clr),
    .isr_clr_q  (poll_isr_clr)
  );

  assign isr_clr   = cmd_clr | poll_isr_clr;
  assign init_busy = (state_q != ST_NORMAL);

endmodule

// File: rtl/pic_prog_if_chk.sv
module pic_prog_if_chk #(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_stb,
  input logic                        rd_stb,
  input logic                        addr,
  input logic [DW-1:0]               wdata,
  input logic                        rd_valid,
  input logic [LINES-1:0]            mask_q,
  input logic [DW-$clog2(LINES)-1:0] vec_base,
  input logic                        special_mask,
  input logic [$clog2(LINES)-1:0]    prio_ofs,
  input logic                        init_busy,
  input logic [LINES-1:0]            isr_clr,
  input logic [LINES-1:0]            irr_clr
);
  // R12
  isr_clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_clr));

  // R11
  irr_clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irr_clr));

  // R11
  irr_clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (irr_clr != '0) |-> rd_valid);

  // R10
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);

  // R10
  rd_valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr && !init_busy) |=> (mask_q == $past(wdata[LINES-1:0])));

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !addr && wdata[4]) |=>
      (mask_q == '0 && prio_ofs == '0 && !special_mask && init_busy));

  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(vec_base));

endmodule

bind pic_prog_if pic_prog_if_chk #(.DW(DW), .LINES(LINES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_stb       (wr_stb),
  .rd_stb       (rd_stb),
  .addr         (addr),
  .wdata        (wdata),
  .rd_valid     (rd_valid),
  .mask_q       (mask_q),
  .vec_base     (vec_base),
  .special_mask (special_mask),
  .prio_ofs     (prio_ofs),
  .init_busy    (init_busy),
  .isr_clr      (isr_clr),
  .irr_clr      (irr_clr)
);

// File: tb/sim_pic_prog_if.sv
module sim_pic_prog_if;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0, rd_stb = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] req_vec = 8'h5A, insvc_vec = 8'hA5;
  logic       res_valid = 1'b0;
  logic [2:0] res_line = 3'd0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] mask_q;
  logic [4:0] vec_base;
  logic       fully_nested, auto_eoi, rot_auto_eoi, special_mask, init_busy;
  logic [2:0] prio_ofs;
  logic [7:0] isr_clr, irr_clr;

  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [7:0] got, got_isr, got_irr;

  pic_prog_if u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wdata(wdata), .req_vec(req_vec), .insvc_vec(insvc_vec),
    .res_valid(res_valid), .res_line(res_line), .rd_data(rd_data),
    .rd_valid(rd_valid), .mask_q(mask_q), .vec_base(vec_base),
    .fully_nested(fully_nested), .auto_eoi(auto_eoi),
    .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask),
    .prio_ofs(prio_ofs), .init_busy(init_busy), .isr_clr(isr_clr),
    .irr_clr(irr_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    got_isr = isr_clr;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    got = rd_data; got_isr = isr_clr; got_irr = irr_clr;
    chk("R10 rd_valid", int'(rd_valid), 1);
  endtask

  function automatic logic [3:0] hi_line(input logic [7:0] v, input logic [2:0] o);
    for (int p = 0; p < 8; p++) begin
      logic [2:0] l;
      l = o + 3'(p);
      if (v[l]) return {1'b1, l};
    end
    return 4'd0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_q, 0);         chk("R1 base", vec_base, 0);
    chk("R1 fnm", fully_nested, 0);    chk("R1 aeoi", auto_eoi, 0);
    chk("R1 rot", rot_auto_eoi, 0);    chk("R1 smm", special_mask, 0);
    chk("R1 ofs", prio_ofs, 0);        chk("R1 busy", init_busy, 0);
    chk("R1 isr_clr", isr_clr, 0);     chk("R1 irr_clr", irr_clr, 0);
    chk("R1 rd_data", rd_data, 0);     chk("R1 rd_valid", rd_valid, 0);
    rd(1'b0);
    chk("R10 reset read selects request", got, 8'h5A);
    @(negedge clk);
    chk("R10 rd_valid one cycle", rd_valid, 0);

    // R2 R3 R4 init sequence with and without fourth word
    for (int four = 0; four < 2; four++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] b, fw;
        b  = 8'(k * 37 + 5);
        fw = {3'b000, k[0], 2'b00, k[1], 1'b0};
        wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h12);
        chk("R4 fnm preset", fully_nested, 1);
        chk("R4 aeoi preset", auto_eoi, 1);
        wr(1, 8'hFF);
        wr(0, 8'hC0 | 8'(k));
        wr(0, 8'h68); wr(0, 8'h0B);
        chk("R2 ofs before", prio_ofs, (k + 1) % 8);
        wr(0, 8'h10 | 8'(four));
        chk("R2 mask cleared", mask_q, 0);
        chk("R2 ofs cleared", prio_ofs, 0);
        chk("R2 smm cleared", special_mask, 0);
        chk("R2 busy", init_busy, 1);
        chk("R2 fnm kept only with fourth", fully_nested, four);
        chk("R2 aeoi kept only with fourth", auto_eoi, four);
        rd(0);
        chk("R2 read-select cleared", got, 8'h5A);
        wr(1, b);
        chk("R3 base", vec_base, int'(b & 8'hF8) >> 3);
        chk("R3 busy after base", init_busy, 1);
        wr(1, 8'h00);
        chk("R3 busy after third", init_busy, four);
        if (four == 1) begin
          wr(1, fw);
          chk("R4 fnm", fully_nested, k[0]);
          chk("R4 aeoi", auto_eoi, k[1]);
          chk("R4 back to normal", init_busy, 0);
        end
        chk("R3 base held", vec_base, int'(b & 8'hF8) >> 3);
      end
    end

    // R5 mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(1, 8'(m));
      chk("R5 mask", mask_q, m);
      rd(1);
      chk("R10 mask read", got, m);
    end

    // R6 mode command
    wr(0, 8'h0B); rd(0); chk("R6 rsel=1 reads insvc", got, 8'hA5);
    wr(0, 8'h09); rd(0); chk("R6 rsel kept when disabled", got, 8'hA5);
    wr(0, 8'h0A); rd(0); chk("R6 rsel=0 reads request", got, 8'h5A);
    wr(0, 8'h68); chk("R6 smm set", special_mask, 1);
    wr(0, 8'h28); chk("R6 smm kept when disabled", special_mask, 1);
    wr(0, 8'h48); chk("R6 smm cleared", special_mask, 0);

    // R7 rotate-on-auto-EOI
    wr(0, 8'h80); chk("R7 rot on", rot_auto_eoi, 1); chk("R7 no strobe", got_isr, 0);
    wr(0, 8'h00); chk("R7 rot off", rot_auto_eoi, 0);

    // R8 non-specific EOI over every offset and pattern
    for (int o = 0; o < 8; o++) begin
      wr(0, 8'hC0 | 8'((o + 7) % 8));
      chk("R9 set offset", prio_ofs, o);
      for (int v = 0; v < 256; v++) begin
        logic [3:0] h;
        insvc_vec = 8'(v);
        h = hi_line(8'(v), 3'(o));
        wr(0, 8'h20);
        chk("R8 eoi line", got_isr, h[3] ? (1 << h[2:0]) : 0);
        chk("R8 eoi keeps offset", prio_ofs, o);
        wr(0, 8'hA0);
        chk("R8 rotating eoi line", got_isr, h[3] ? (1 << h[2:0]) : 0);
        chk("R8 rotating eoi offset", prio_ofs, h[3] ? (h[2:0] + 1) % 8 : o);
        @(negedge clk);
        chk("R12 strobe one cycle", isr_clr, 0);
        wr(0, 8'hC0 | 8'((o + 7) % 8));
      end
    end
    insvc_vec = 8'hA5;

    // R9 specific commands
    for (int l = 0; l < 8; l++) begin
      wr(0, 8'hC0 | 8'(l));
      wr(0, 8'h60 | 8'(l));
      chk("R9 specific clear", got_isr, 1 << l);
      chk("R9 specific keeps offset", prio_ofs, (l + 1) % 8);
      wr(0, 8'hE0 | 8'((l + 3) % 8));
      chk("R9 clear and rotate", got_isr, 1 << ((l + 3) % 8));
      chk("R9 clear and rotate offset", prio_ofs, (l + 4) % 8);
      wr(0, 8'h40 | 8'(l));
      chk("R9 nop strobe", got_isr, 0);
      chk("R9 nop offset", prio_ofs, (l + 4) % 8);
      chk("R9 nop rot", rot_auto_eoi, 0);
    end

    // R11 poll reads
    wr(1, 8'h3C);
    for (int l = 0; l < 9; l++) begin
      res_valid = (l < 8);
      res_line  = 3'(l);
      wr(0, 8'h0C);
      rd(1);
      chk("R11 poll data", got, l < 8 ? l : 7);
      chk("R11 poll irr strobe", got_irr, l < 8 ? (1 << l) : 0);
      chk("R11 poll isr strobe", got_isr, l < 8 ? (1 << l) : 0);
      rd(1);
      chk("R11 poll disarmed", got, 8'h3C);
      chk("R11 no strobe after", got_irr, 0);
    end

    summary();
    $finish;
  end

endmodule